// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Registers

This block performs one long arithmetic operation at a time on two operand words. A one-cycle start strobe picks either a multiply or a divide, signed or unsigned. A multiply produces a double-width product. A divide produces a quotient and a remainder. Either result is written into one shared pair of result registers: the upper half of a product, or the remainder, goes to `hi`, and the lower half of a product, or the quotient, goes to `lo`.

The multiply is a shift-add loop and the divide is a restoring loop. Each resolves one bit per clock. Signed operations run on magnitudes, and the signs are applied in the final cycle. While an operation runs, `busy` is high and further start strobes are dropped. When it ends, `done` pulses and the result registers change together. A divide by zero ends normally and leaves a fixed, defined result.

Top module: `hmd_top`

## Requirements
- R1: With `op_div`=0 and `op_signed`=0, the unsigned 64-bit product of `opnd_a` and `opnd_b` appears with bits 63..32 on `hi` and bits 31..0 on `lo`.
- R2: With `op_div`=0 and `op_signed`=1, `{hi,lo}` is the two's-complement 64-bit product of the operands read as signed values.
- R3: With `op_div`=1 and `op_signed`=0, `lo` receives the unsigned quotient `opnd_a / opnd_b` and `hi` the unsigned remainder.
- R4: With `op_div`=1 and `op_signed`=1, the quotient is truncated toward zero, so it is negative when the operand signs differ. The remainder carries the sign of the dividend. Dividing the most negative value by -1 gives quotient 0x80000000 and remainder 0.
- R5: A start that is accepted at a clock edge makes `busy` high for exactly 32 cycles. In the first cycle after `busy` falls, `done` is high for exactly one cycle.
- R6: `hi` and `lo` keep their values at every edge except the one that ends an operation, and at that edge both registers change together.
- R7: A divide with `opnd_b`=0 completes with the normal timing. `lo` becomes all ones and `hi` equals `opnd_a`, in both signed and unsigned mode.
- R8: A start seen while `busy` is high is ignored. The running operation keeps its operands and its timing, and no second operation follows it.
- R9: While `rst_n` is low, `busy`, `done`, `hi` and `lo` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle command strobe, taken only when idle |
| op_div | input | 1 | 0 selects multiply, 1 selects divide |
| op_signed | input | 1 | 1 treats the operands as two's complement |
| opnd_a | input | 32 | Multiplicand, or dividend |
| opnd_b | input | 32 | Multiplier, or divisor |
| busy | output | 1 | High while an operation iterates |
| done | output | 1 | One-cycle pulse when the results are written |
| hi | output | 32 | Upper product half, or remainder |
| lo | output | 32 | Lower product half, or quotient |

## Verification
The case hardest to reach from the ports is a start strobe that lands mid-operation, carrying different operands. If the design captured that strobe, it would change the result, stretch `busy`, or append a second `done`. The bench raises such a strobe partway through selected operations and checks three things: the result still matches the first command, the busy count is still 32, and the cycle after `done` is idle. Signed corner values are also driven, including the most negative dividend over -1 and zero divisors with negative dividends, so that the sign fix-up and the zero-divisor override are exercised together.

// File: rtl/hmd_pkg.sv
package hmd_pkg;
   typedef enum logic {
      OP_MUL = 1'b0,
      OP_DIV = 1'b1
   } hmd_op_e;

   function automatic logic [31:0] hmd_mag32(input logic [31:0] v, input logic neg);
      return neg ? (~v + 32'd1) : v;
   endfunction
endpackage

// File: rtl/hmd_operand_prep.sv
module hmd_operand_prep #(
   parameter int WIDTH       = 32,
   parameter bit SIGNED_SUPP = 1'b1
) (
   input  logic             is_div,
   input  logic             is_signed,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] mag_a,
   output logic [WIDTH-1:0] mag_b,
   output logic             neg_main,
   output logic             neg_rem,
   output logic             zero_div
);
   logic sa, sb;

   generate
      if (SIGNED_SUPP) begin : g_signed
         assign sa = is_signed & a[WIDTH-1];
         assign sb = is_signed & b[WIDTH-1];
      end else begin : g_unsigned
         assign sa = 1'b0;
         assign sb = 1'b0;
      end
   endgenerate

   always_comb begin
      mag_a    = sa ? (~a + {{(WIDTH-1){1'b0}}, 1'b1}) : a;
      mag_b    = sb ? (~b + {{(WIDTH-1){1'b0}}, 1'b1}) : b;
      neg_main = sa ^ sb;
      neg_rem  = sa;
      zero_div = is_div & (b == '0);
   end
endmodule

// File: rtl/hmd_seq_ctrl.sv
module hmd_seq_ctrl #(
   parameter int WIDTH = 32,
   localparam int CW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic step,
   output logic last,
   output logic busy,
   output logic done
);
   localparam logic [CW-1:0] LAST_CNT = CW'(WIDTH - 1);

   logic          busy_r, done_r;
   logic [CW-1:0] cnt_r;

   assign accept = start & ~busy_r;
   assign step   = busy_r;
   assign last   = busy_r & (cnt_r == LAST_CNT);
   assign busy   = busy_r;
   assign done   = done_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_r <= 1'b0;
         done_r <= 1'b0;
         cnt_r  <= '0;
      end else begin
         done_r <= last;
         if (accept) begin
            busy_r <= 1'b1;
            cnt_r  <= '0;
         end else if (busy_r) begin
            cnt_r <= cnt_r + 1'b1;
            if (last) busy_r <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/hmd_datapath.sv
module hmd_datapath #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic             is_div,
   input  logic [WIDTH-1:0] mag_a,
   input  logic [WIDTH-1:0] mag_b,
   output logic [WIDTH-1:0] nxt_hi,
   output logic [WIDTH-1:0] nxt_lo
);
   logic             div_r;
   logic [WIDTH-1:0] hi_r, lo_r, opb_r;
   logic [WIDTH:0]   mul_sum, div_trial;

   always_comb begin
      mul_sum   = {1'b0, hi_r} + (lo_r[0] ? {1'b0, opb_r} : '0);
      div_trial = {hi_r, lo_r[WIDTH-1]} - {1'b0, opb_r};
      if (!div_r) begin
         {nxt_hi, nxt_lo} = {mul_sum, lo_r[WIDTH-1:1]};
      end else if (!div_trial[WIDTH]) begin
         nxt_hi = div_trial[WIDTH-1:0];
         nxt_lo = {lo_r[WIDTH-2:0], 1'b1};
      end else begin
         nxt_hi = {hi_r[WIDTH-2:0], lo_r[WIDTH-1]};
         nxt_lo = {lo_r[WIDTH-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_r <= 1'b0;
         hi_r  <= '0;
         lo_r  <= '0;
         opb_r <= '0;
      end else if (load) begin
         div_r <= is_div;
         hi_r  <= '0;
         lo_r  <= mag_a;
         opb_r <= mag_b;
      end else if (step) begin
         hi_r <= nxt_hi;
         lo_r <= nxt_lo;
      end
   end
endmodule

// File: rtl/hmd_result_fix.sv
module hmd_result_fix #(
   parameter int WIDTH = 32
) (
   input  logic             is_div,
   input  logic             neg_main,
   input  logic             neg_rem,
   input  logic             zero_div,
   input  logic [WIDTH-1:0] raw_hi,
   input  logic [WIDTH-1:0] raw_lo,
   output logic [WIDTH-1:0] res_hi,
   output logic [WIDTH-1:0] res_lo
);
   logic [2*WIDTH-1:0] prod;
   logic [WIDTH-1:0]   quo, rem;

   always_comb begin
      prod = {raw_hi, raw_lo};
      if (neg_main) prod = ~prod + {{(2*WIDTH-1){1'b0}}, 1'b1};
      quo = neg_main ? (~raw_lo + {{(WIDTH-1){1'b0}}, 1'b1}) : raw_lo;
      rem = neg_rem  ? (~raw_hi + {{(WIDTH-1){1'b0}}, 1'b1}) : raw_hi;
      if (zero_div) quo = '1;
      if (is_div) begin
         res_hi = rem;
         res_lo = quo;
      end else begin
         res_hi = prod[2*WIDTH-1:WIDTH];
         res_lo = prod[WIDTH-1:0];
      end
   end
endmodule

// File: rtl/hmd_top.sv
module hmd_top #(
   parameter int WIDTH       = 32,
   parameter bit SIGNED_SUPP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             op_div,
   input  logic             op_signed,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] hi,
   output logic [WIDTH-1:0] lo
);
   import hmd_pkg::*;

   generate
      if (WIDTH < 4) begin : g_bad_width
         $error("hmd_top: WIDTH must be at least 4");
      end
   endgenerate

   logic             accept, step, last;
   logic [WIDTH-1:0] mag_a, mag_b, nxt_hi, nxt_lo, res_hi, res_lo;
   logic             p_neg_main, p_neg_rem, p_zero;
   logic             neg_main_r, neg_rem_r, zero_r;
   hmd_op_e          op_r;
   logic [WIDTH-1:0] hi_r, lo_r;

   hmd_operand_prep #(.WIDTH(WIDTH), .SIGNED_SUPP(SIGNED_SUPP)) u_prep (
      .is_div   (op_div),
      .is_signed(op_signed),
      .a        (opnd_a),
      .b        (opnd_b),
      .mag_a    (mag_a),
      .mag_b    (mag_b),
      .neg_main (p_neg_main),
      .neg_rem  (p_neg_rem),
      .zero_div (p_zero)
   );

   hmd_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .accept(accept),
      .step  (step),
      .last  (last),
      .busy  (busy),
      .done  (done)
   );

   hmd_datapath #(.WIDTH(WIDTH)) u_dp (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .step  (step),
      .is_div(op_div),
      .mag_a (mag_a),
      .mag_b (mag_b),
      .nxt_hi(nxt_hi),
      .nxt_lo(nxt_lo)
   );

   hmd_result_fix #(.WIDTH(WIDTH)) u_fix (
      .is_div  (op_r == OP_DIV),
      .neg_main(neg_main_r),
      .neg_rem (neg_rem_r),
      .zero_div(zero_r),
      .raw_hi  (nxt_hi),
      .raw_lo  (nxt_lo),
      .res_hi  (res_hi),
      .res_lo  (res_lo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_r       <= OP_MUL;
         neg_main_r <= 1'b0;
         neg_rem_r  <= 1'b0;
         zero_r     <= 1'b0;
         hi_r       <= '0;
         lo_r       <= '0;
      end else begin
         if (accept) begin
            op_r       <= op_div ? OP_DIV : OP_MUL;
            neg_main_r <= p_neg_main;
            neg_rem_r  <= p_neg_rem;
            zero_r     <= p_zero;
         end
         if (last) begin
            hi_r <= res_hi;
            lo_r <= res_lo;
         end
      end
   end

   assign hi = hi_r;
   assign lo = lo_r;
endmodule

// File: rtl/hmd_checker.sv
module hmd_checker #(
   parameter int WIDTH = 32,
   localparam int BW   = $clog2(WIDTH + 2)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [WIDTH-1:0] hi,
   input logic [WIDTH-1:0] lo
);
   logic [BW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_cnt <= '0;
      else if (busy) run_cnt <= run_cnt + 1'b1;
      else           run_cnt <= '0;
   end

   // R5: an idle start is always taken
   a_r5_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R5: done lasts one cycle
   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5: done follows exactly WIDTH busy cycles
   a_r5_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && run_cnt == BW'(WIDTH)));

   // R5: a busy run never exceeds WIDTH cycles
   a_r5_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= BW'(WIDTH));

   // R6: result registers only move together with done
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(hi) || !$stable(lo)) |-> done);

   // R8: a start during busy neither ends nor restarts the run
   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && run_cnt < BW'(WIDTH - 1)) |=> (busy && run_cnt != '0));
endmodule

bind hmd_top hmd_checker #(.WIDTH(WIDTH)) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .start(start),
   .busy (busy),
   .done (done),
   .hi   (hi),
   .lo   (lo)
);

// File: tb/sim_hmd_top.sv
module sim_hmd_top;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0, op_div = 1'b0, op_signed = 1'b0;
   logic [W-1:0] opnd_a = '0, opnd_b = '0;
   logic         busy, done;
   logic [W-1:0] hi, lo;

   int n_chk = 0, n_bad = 0;
   logic [2*W-1:0] exp_q[$];
   string          tag_q[$];

   always #5 clk = ~clk;

   hmd_top u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
      .op_signed(op_signed), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .busy(busy), .done(done), .hi(hi), .lo(lo)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [2*W-1:0] model(input logic dv, input logic sg,
                                            input logic [W-1:0] a, input logic [W-1:0] b);
      longint sa, sb, q, r;
      logic [63:0] p;
      if (!dv) begin
         if (sg) p = 64'($signed(a)) * 64'($signed(b));
         else    p = {32'd0, a} * {32'd0, b};
         return p;
      end
      if (b == '0) return {a, {W{1'b1}}};
      if (sg) begin
         sa = longint'($signed(a)); sb = longint'($signed(b));
         q = sa / sb; r = sa % sb;
      end else begin
         sa = longint'({32'd0, a}); sb = longint'({32'd0, b});
         q = sa / sb; r = sa % sb;
      end
      return {r[31:0], q[31:0]};
   endfunction

   // monitor: pops the scoreboard whenever a result is reported
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            check("R8 unexpected done", 64'd1, 64'd0);
         end else begin
            logic [2*W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {hi, lo}, e);
         end
      end
   end

   // driver: issues one command, optionally injects a stray start mid-run
   task automatic run_op(input string req, input logic dv, input logic sg,
                         input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit inject);
      int cnt;
      logic [W-1:0] h0, l0;
      @(negedge clk);
      exp_q.push_back(model(dv, sg, a, b));
      tag_q.push_back(req);
      h0 = hi; l0 = lo;
      op_div = dv; op_signed = sg; opnd_a = a; opnd_b = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      opnd_a = ~a; opnd_b = b + 32'd3;
      cnt = 0;
      while (busy && cnt < 100) begin
         cnt++;
         if (hi !== h0 || lo !== l0) check("R6 hold during busy", {hi, lo}, {h0, l0});
         if (inject && cnt == 7) begin
            start = 1'b1; op_div = ~dv; op_signed = ~sg;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      check({req, " R5 busy cycles"}, 64'(cnt), 64'd32);
      check("R5 done after busy", 64'(done), 64'd1);
      @(negedge clk);
      check("R5 R8 idle after done", {62'd0, busy, done}, 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset state", {30'd0, busy, done, hi}, 64'd0);
      check("R9 reset lo", 64'(lo), 64'd0);
      rst_n = 1'b1;
      run_op("R1 unsigned mul", 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      run_op("R1 unsigned mul", 1'b0, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0, 1'b0);
      run_op("R2 signed mul neg*pos", 1'b0, 1'b1, 32'hFFFF_FFFD, 32'd7, 1'b0);
      run_op("R2 signed mul min*min", 1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000, 1'b0);
      run_op("R2 signed mul neg*neg", 1'b0, 1'b1, 32'hFFFF_0000, 32'h8000_0001, 1'b0);
      run_op("R3 unsigned div", 1'b1, 1'b0, 32'd1000, 32'd7, 1'b0);
      run_op("R3 unsigned div large", 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0001_0003, 1'b0);
      run_op("R4 signed div neg/pos", 1'b1, 1'b1, 32'hFFFF_FF9C, 32'd7, 1'b0);
      run_op("R4 signed div pos/neg", 1'b1, 1'b1, 32'd100, 32'hFFFF_FFF9, 1'b0);
      run_op("R4 signed div min/-1", 1'b1, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
      run_op("R7 div zero unsigned", 1'b1, 1'b0, 32'hDEAD_BEEF, 32'd0, 1'b0);
      run_op("R7 div zero signed neg", 1'b1, 1'b1, 32'hFFFF_FF00, 32'd0, 1'b0);
      run_op("R8 stray start mul", 1'b0, 1'b1, 32'h0BAD_F00D, 32'hFFFF_FF11, 1'b1);
      run_op("R8 stray start div", 1'b1, 1'b0, 32'h7654_3210, 32'd13, 1'b1);
      repeat (3) @(negedge clk);
      check("R6 R8 scoreboard empty", 64'(exp_q.size()), 64'd0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule